// File: doc/BRIEF.md
# Divide and Square-Root Subnormal Trap Classifier

This block sits beside a floating-point divide and square-root unit. It decides, before the arithmetic starts, what kind of trap an operation with subnormal inputs or a subnormal result will raise. Each operation is presented for one cycle with two operands, a precision select, an operation select and the underflow trap mask. One cycle later the block returns one outcome: no exception, IEEE overflow, IEEE underflow, or unfinished. Unfinished means the operation is handed to software emulation.

For a divide, the block forms a biased exponent difference D = Ea - Eb + Bias and compares it against 1 and MaxExp. A subnormal dividend takes exponent 0 and fraction 0. A subnormal divisor takes exponent 1 and fraction 1. When D sits exactly on a boundary, the fractions are compared to settle the case. Results that would be subnormal go to software or to an underflow trap, as the mask selects. The block does not compute a quotient or a root, and it does not round.

Top module: `fpdt_classifier`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle with `op_valid` high, and low otherwise. `res_code` reads 0 whenever `res_valid` is low, including after reset. The codes are 0 none, 1 overflow, 2 underflow, 3 unfinished.
- R2: Single precision uses `opnd_a`/`opnd_b` bits [31:0], with sign 31, exponent [30:23] and fraction [22:0]; bits [63:32] have no effect. Double precision uses sign 63, exponent [62:52] and fraction [51:0]. An operand is subnormal when its exponent is 0 and its fraction is nonzero. It is normal when its exponent is neither 0 nor all ones.
- R3: Square root (`op_is_sqrt`=1) uses `opnd_b` only. A positive subnormal gives 3. Any other value, including a negative subnormal, gives 0. Square root never gives 1 or 2.
- R4: A divide with both operands subnormal gives 3.
- R5: A divide with one subnormal operand gives 0 when the other operand is zero, infinity or NaN.
- R6: Normal dividend over subnormal divisor: D = Ea - 1 + Bias. D >= MaxExp gives 1; otherwise the result is 3.
- R7: Subnormal dividend over normal divisor: D = Bias - Eb. D >= 1 gives 3. D < 1 gives 3 when `uf_mask`=0 and 2 when `uf_mask`=1.
- R8: Both operands normal: D > MaxExp gives 1. D = MaxExp gives 1 when Fa >= Fb and 0 when Fa < Fb.
- R9: Both operands normal with 1 < D < MaxExp, or with D = 1 and Fa >= Fb, gives 0.
- R10: Both operands normal with D = 1 and Fa < Fb, or with D < 1, gives 3 when `uf_mask`=0 and 2 when `uf_mask`=1.
- R11: A divide with no subnormal operand and at least one zero, infinity or NaN operand gives 0.

Bias is 127 for single precision and 1023 for double. MaxExp is 255 for single and 2047 for double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_is_double | input | 1 | 1 selects double precision, 0 single |
| op_is_sqrt | input | 1 | 1 selects square root, 0 divide |
| uf_mask | input | 1 | Underflow trap enable mask |
| opnd_a | input | 64 | Dividend (ignored for square root) |
| opnd_b | input | 64 | Divisor or square-root operand |
| res_valid | output | 1 | Outcome valid, one cycle after `op_valid` |
| res_code | output | 2 | Outcome code |

## Verification
The properties assume that the operands, the selects and the mask carry known values in every cycle where `op_valid` is high. They also assume that `op_valid` is low during reset. The bench meets both assumptions. It drives every input on the falling clock edge, holds `op_valid` low through reset, and clears the operands between operations. Because the one-cycle pulse shape is checked in every cycle, `op_valid` is raised for exactly one cycle per operation.

// File: rtl/fpdt_pkg.sv
package fpdt_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_FRC_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_FRC_W = 52;
  localparam int SP_W     = 1 + SP_EXP_W + SP_FRC_W;
  localparam int DP_W     = 1 + DP_EXP_W + DP_FRC_W;
  localparam int WORD_W   = DP_W;
  localparam int FRC_PAD  = DP_FRC_W - SP_FRC_W;
  localparam int EXP_PAD  = DP_EXP_W - SP_EXP_W;
  // signed difference: exponent + bias can exceed MaxExp, plus a sign bit
  localparam int D_W      = DP_EXP_W + 2;
  localparam int N_OPND   = 2;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_OVF   = 2'd1,
    OUT_UNF   = 2'd2,
    OUT_UNFIN = 2'd3
  } outcome_e;

  typedef struct packed {
    logic                sign;
    logic                zero;
    logic                sub;
    logic                norm;
    logic                special;
    logic [DP_EXP_W-1:0] exp;
    logic [DP_FRC_W-1:0] frc;
  } opnd_t;

  function automatic logic signed [D_W-1:0] bias_of(input logic dbl);
    return dbl ? D_W'((1 << (DP_EXP_W-1)) - 1) : D_W'((1 << (SP_EXP_W-1)) - 1);
  endfunction

  function automatic logic signed [D_W-1:0] maxexp_of(input logic dbl);
    return dbl ? D_W'((1 << DP_EXP_W) - 1) : D_W'((1 << SP_EXP_W) - 1);
  endfunction
endpackage

// File: rtl/fpdt_unpack.sv
module fpdt_unpack
  import fpdt_pkg::*;
(
  input  logic              is_double,
  input  logic [WORD_W-1:0] word,
  output opnd_t             opnd
);
  logic                sp_sign, dp_sign;
  logic [SP_EXP_W-1:0] sp_exp;
  logic [SP_FRC_W-1:0] sp_frc;
  logic [DP_EXP_W-1:0] dp_exp;
  logic [DP_FRC_W-1:0] dp_frc;
  logic                exp_zero, exp_ones, frc_zero;

  assign sp_sign = word[SP_W-1];
  assign sp_exp  = word[SP_W-2 -: SP_EXP_W];
  assign sp_frc  = word[SP_FRC_W-1:0];
  assign dp_sign = word[DP_W-1];
  assign dp_exp  = word[DP_W-2 -: DP_EXP_W];
  assign dp_frc  = word[DP_FRC_W-1:0];

  always_comb begin
    if (is_double) begin
      exp_zero = (dp_exp == '0);
      exp_ones = (dp_exp == '1);
      frc_zero = (dp_frc == '0);
    end else begin
      exp_zero = (sp_exp == '0);
      exp_ones = (sp_exp == '1);
      frc_zero = (sp_frc == '0);
    end
  end

  always_comb begin
    opnd.sign    = is_double ? dp_sign : sp_sign;
    // single fields are widened: exponent zero-extended, fraction left-aligned
    opnd.exp     = is_double ? dp_exp : {{EXP_PAD{1'b0}}, sp_exp};
    opnd.frc     = is_double ? dp_frc : {sp_frc, {FRC_PAD{1'b0}}};
    opnd.zero    = exp_zero & frc_zero;
    opnd.sub     = exp_zero & ~frc_zero;
    opnd.norm    = ~exp_zero & ~exp_ones;
    opnd.special = exp_ones | (exp_zero & frc_zero);
  end
endmodule

// File: rtl/fpdt_predict.sv
module fpdt_predict
  import fpdt_pkg::*;
(
  input  logic                  is_double,
  input  opnd_t                 a,
  input  opnd_t                 b,
  output logic signed [D_W-1:0] diff,
  output logic                  d_gt_max,
  output logic                  d_eq_max,
  output logic                  d_eq_one,
  output logic                  d_lt_one,
  output logic                  frc_ge
);
  localparam logic signed [D_W-1:0] ONE = D_W'(1);

  // substitutes: subnormal dividend -> exp 0 / frc 0, subnormal divisor -> exp 1 / frc 1
  function automatic logic [DP_EXP_W-1:0] eff_exp(input opnd_t o, input logic divisor);
    if (o.sub) return divisor ? DP_EXP_W'(1) : '0;
    return o.exp;
  endfunction

  function automatic logic [DP_FRC_W-1:0] eff_frc(input opnd_t o, input logic divisor);
    if (o.sub) return divisor ? DP_FRC_W'(1) : '0;
    return o.frc;
  endfunction

  function automatic logic signed [D_W-1:0] exp_diff(input logic [DP_EXP_W-1:0] ea,
                                                     input logic [DP_EXP_W-1:0] eb,
                                                     input logic dbl);
    return $signed({2'b00, ea}) - $signed({2'b00, eb}) + bias_of(dbl);
  endfunction

  logic signed [D_W-1:0] max_e;

  assign max_e    = maxexp_of(is_double);
  assign diff     = exp_diff(eff_exp(a, 1'b0), eff_exp(b, 1'b1), is_double);
  assign d_gt_max = diff > max_e;
  assign d_eq_max = diff == max_e;
  assign d_eq_one = diff == ONE;
  assign d_lt_one = diff < ONE;
  assign frc_ge   = eff_frc(a, 1'b0) >= eff_frc(b, 1'b1);
endmodule

// File: rtl/fpdt_decide.sv
module fpdt_decide
  import fpdt_pkg::*;
(
  input  logic     is_sqrt,
  input  logic     uf_mask,
  input  opnd_t    a,
  input  opnd_t    b,
  input  logic     d_gt_max,
  input  logic     d_eq_max,
  input  logic     d_eq_one,
  input  logic     d_lt_one,
  input  logic     frc_ge,
  output logic     both_sub,
  output logic     nn_case,
  output outcome_e outcome
);
  logic     sn_case, ns_case;
  outcome_e tiny_res;

  assign both_sub = a.sub & b.sub;
  assign sn_case  = a.sub & b.norm;
  assign ns_case  = a.norm & b.sub;
  assign nn_case  = a.norm & b.norm;
  // a tiny result goes to software unless underflow traps are enabled
  assign tiny_res = uf_mask ? OUT_UNF : OUT_UNFIN;

  always_comb begin
    outcome = OUT_NONE;
    if (is_sqrt) begin
      if (b.sub && !b.sign) outcome = OUT_UNFIN;
    end else if (both_sub) begin
      outcome = OUT_UNFIN;
    end else if (sn_case) begin
      outcome = d_lt_one ? tiny_res : OUT_UNFIN;
    end else if (ns_case) begin
      outcome = (d_gt_max || d_eq_max) ? OUT_OVF : OUT_UNFIN;
    end else if (nn_case) begin
      if (d_gt_max)      outcome = OUT_OVF;
      else if (d_eq_max) outcome = frc_ge ? OUT_OVF : OUT_NONE;
      else if (d_eq_one) outcome = frc_ge ? OUT_NONE : tiny_res;
      else if (d_lt_one) outcome = tiny_res;
      else               outcome = OUT_NONE;
    end
  end
endmodule

// File: rtl/fpdt_classifier.sv
module fpdt_classifier
  import fpdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_is_double,
  input  logic              op_is_sqrt,
  input  logic              uf_mask,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic              res_valid,
  output logic [1:0]        res_code
);
  logic [WORD_W-1:0]     words [N_OPND];
  opnd_t                 opnds [N_OPND];
  logic signed [D_W-1:0] diff;
  logic                  d_gt_max, d_eq_max, d_eq_one, d_lt_one, frc_ge;
  logic                  both_sub, nn_case;
  outcome_e              next_code, code_q;

  assign words[0] = opnd_a;
  assign words[1] = opnd_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
    fpdt_unpack u_unpack (
      .is_double (op_is_double),
      .word      (words[gi]),
      .opnd      (opnds[gi])
    );
  end

  fpdt_predict u_predict (
    .is_double (op_is_double),
    .a         (opnds[0]),
    .b         (opnds[1]),
    .diff      (diff),
    .d_gt_max  (d_gt_max),
    .d_eq_max  (d_eq_max),
    .d_eq_one  (d_eq_one),
    .d_lt_one  (d_lt_one),
    .frc_ge    (frc_ge)
  );

  fpdt_decide u_decide (
    .is_sqrt  (op_is_sqrt),
    .uf_mask  (uf_mask),
    .a        (opnds[0]),
    .b        (opnds[1]),
    .d_gt_max (d_gt_max),
    .d_eq_max (d_eq_max),
    .d_eq_one (d_eq_one),
    .d_lt_one (d_lt_one),
    .frc_ge   (frc_ge),
    .both_sub (both_sub),
    .nn_case  (nn_case),
    .outcome  (next_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      code_q    <= OUT_NONE;
    end else begin
      res_valid <= op_valid;
      code_q    <= op_valid ? next_code : OUT_NONE;
    end
  end

  assign res_code = code_q;
endmodule

// File: rtl/fpdt_checker.sv
module fpdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_is_sqrt,
  input logic       uf_mask,
  input logic       both_sub,
  input logic       nn_case,
  input logic       d_gt_max,
  input logic       res_valid,
  input logic [1:0] res_code
);
  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && res_code == 2'd0));
  assert_sqrt_no_ieee_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_sqrt) |=> (res_code == 2'd0 || res_code == 2'd3));
  assert_both_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_is_sqrt && both_sub) |=> res_code == 2'd3);
  assert_over_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_is_sqrt && nn_case && d_gt_max) |=> res_code == 2'd1);
  assert_unf_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !uf_mask) |=> res_code != 2'd2);
endmodule

bind fpdt_classifier fpdt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_is_sqrt (op_is_sqrt),
  .uf_mask    (uf_mask),
  .both_sub   (both_sub),
  .nn_case    (nn_case),
  .d_gt_max   (d_gt_max),
  .res_valid  (res_valid),
  .res_code   (res_code)
);

// File: tb/fpdt_classifier_tb.sv
`timescale 1ns/1ps
module fpdt_classifier_tb;
  localparam logic [1:0] NONE = 2'd0, OVF = 2'd1, UNF = 2'd2, UNFIN = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_is_double = 1'b0, op_is_sqrt = 1'b0, uf_mask = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        res_valid;
  logic [1:0]  res_code;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  fpdt_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_double(op_is_double),
    .op_is_sqrt(op_is_sqrt), .uf_mask(uf_mask), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_code(res_code)
  );

  function automatic logic [63:0] mk(bit dbl, bit s, int e, longint unsigned f);
    logic [63:0] w;
    if (dbl) w = {s, e[10:0], f[51:0]};
    else     w = {32'h0, s, e[7:0], f[22:0]};
    return w;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(string req, bit dbl, bit sq, bit m,
                        logic [63:0] a, logic [63:0] b, logic [1:0] exp);
    @(negedge clk);
    op_valid = 1'b1; op_is_double = dbl; op_is_sqrt = sq; uf_mask = m;
    opnd_a = a; opnd_b = b;
    @(negedge clk);
    op_valid = 1'b0; opnd_a = '0; opnd_b = '0;
    check({req, " valid"}, {1'b0, res_valid}, 2'd1);
    check(req, res_code, exp);
  endtask

  task automatic t_reset();
    check("R1 reset valid", {1'b0, res_valid}, 2'd0);
    check("R1 reset code", res_code, NONE);
  endtask

  task automatic t_pulse();
    run_op("R1 pulse op", 0, 0, 0, mk(0,0,0,3), mk(0,0,0,7), UNFIN);
    @(negedge clk);
    check("R1 pulse drop valid", {1'b0, res_valid}, 2'd0);
    check("R1 pulse drop code", res_code, NONE);
  endtask

  task automatic t_sqrt();
    run_op("R3 sqrt pos sub", 0, 1, 0, mk(0,0,0,9), mk(0,0,0,5), UNFIN);
    run_op("R3 sqrt neg sub", 0, 1, 1, '0, mk(0,1,0,5), NONE);
    run_op("R3 sqrt normal", 1, 1, 0, mk(1,0,0,1), mk(1,0,1000,5), NONE);
    run_op("R3 sqrt dbl sub", 1, 1, 1, mk(1,0,2046,1), mk(1,0,0,1), UNFIN);
  endtask

  task automatic t_both_sub();
    run_op("R4 both sub sp", 0, 0, 1, mk(0,0,0,1), mk(0,1,0,100), UNFIN);
    run_op("R4 both sub dp", 1, 0, 0, mk(1,1,0,77), mk(1,0,0,2), UNFIN);
  endtask

  task automatic t_sub_special();
    run_op("R5 sub/zero", 0, 0, 0, mk(0,0,0,4), mk(0,0,0,0), NONE);
    run_op("R5 sub/inf", 0, 0, 0, mk(0,0,0,4), mk(0,0,255,0), NONE);
    run_op("R5 nan/sub", 1, 0, 0, mk(1,0,2047,3), mk(1,0,0,4), NONE);
  endtask

  task automatic t_norm_over_sub();
    run_op("R6 D=Max ovf", 0, 0, 0, mk(0,0,129,0), mk(0,0,0,8), OVF);
    run_op("R6 D>Max ovf", 0, 0, 0, mk(0,0,200,0), mk(0,0,0,8), OVF);
    run_op("R6 D<Max unfin", 0, 0, 0, mk(0,0,128,5), mk(0,0,0,8), UNFIN);
    run_op("R6 dp unfin", 1, 0, 1, mk(1,0,1,0), mk(1,0,0,8), UNFIN);
  endtask

  task automatic t_sub_over_norm();
    run_op("R7 D=1 unfin", 0, 0, 1, mk(0,0,0,5), mk(0,0,126,0), UNFIN);
    run_op("R7 D=0 mask0", 0, 0, 0, mk(0,0,0,5), mk(0,0,127,0), UNFIN);
    run_op("R7 D=0 mask1", 0, 0, 1, mk(0,0,0,5), mk(0,0,127,0), UNF);
    run_op("R7 dp D<0 mask1", 1, 0, 1, mk(1,0,0,5), mk(1,0,1024,0), UNF);
  endtask

  task automatic t_nn_high();
    run_op("R8 D>Max", 0, 0, 0, mk(0,0,201,0), mk(0,0,72,9), OVF);
    run_op("R8 D=Max fa>=fb", 0, 0, 0, mk(0,0,200,5), mk(0,0,72,5), OVF);
    run_op("R8 D=Max fa<fb", 0, 0, 1, mk(0,0,200,4), mk(0,0,72,5), NONE);
    run_op("R8 dp D=Max", 1, 0, 0, mk(1,0,1025,6), mk(1,0,1,6), OVF);
  endtask

  task automatic t_nn_mid();
    run_op("R9 mid", 0, 0, 1, mk(0,0,130,1), mk(0,0,130,2), NONE);
    run_op("R9 D=1 fa>=fb", 0, 0, 1, mk(0,0,1,9), mk(0,0,127,3), NONE);
    run_op("R9 dp mid", 1, 0, 0, mk(1,1,1500,0), mk(1,0,1400,7), NONE);
  endtask

  task automatic t_nn_low();
    run_op("R10 D=1 fa<fb mask0", 0, 0, 0, mk(0,0,1,2), mk(0,0,127,3), UNFIN);
    run_op("R10 D=1 fa<fb mask1", 0, 0, 1, mk(0,0,1,2), mk(0,0,127,3), UNF);
    run_op("R10 D<1 mask0", 0, 0, 0, mk(0,0,1,0), mk(0,0,200,0), UNFIN);
    run_op("R10 D<1 mask1", 1, 0, 1, mk(1,0,1,0), mk(1,0,2000,0), UNF);
  endtask

  task automatic t_specials();
    run_op("R11 zero/norm", 0, 0, 1, mk(0,0,0,0), mk(0,0,254,0), NONE);
    run_op("R11 norm/inf", 1, 0, 1, mk(1,0,1,0), mk(1,0,2047,0), NONE);
  endtask

  task automatic t_upper_ignored();
    run_op("R2 upper bits sp", 0, 0, 1,
           mk(0,0,0,5) | 64'hFFF0_0000_0000_0000, mk(0,0,127,0) | 64'h0000_0001_0000_0000, UNF);
    run_op("R2 upper bits sqrt", 0, 1, 0, 64'h0,
           mk(0,0,0,1) | 64'h8000_0000_0000_0000, UNFIN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_sqrt();
    t_both_sub();
    t_sub_special();
    t_norm_over_sub();
    t_sub_over_norm();
    t_nn_high();
    t_nn_mid();
    t_nn_low();
    t_specials();
    t_upper_ignored();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule